// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a register-mapped serial port that drives an SPI bus as master. Software programs a frame width between 4 and 16 bits, the serial clock's idle level and its sampling edge, and a two-stage clock divider. It then writes words into an eight-entry transmit queue. Each queued word is shifted out MSB first on `mosi`. For every frame sent, exactly one frame is clocked in from `miso` and lands right-justified in an eight-entry receive queue. Chip selects are left to general-purpose pins elsewhere on the chip.

The configuration is copied into a working set only while the port is disabled and idle. A new width, mode or rate therefore takes effect through a disable/re-enable cycle and never in the middle of a frame. A loopback switch routes the outgoing bit stream back into the receiver. A sticky overrun flag records a frame that arrived when the receive queue had no room. Three maskable request sources are ORed onto one interrupt line.

Top module: `ssp_master`

## Requirements
- R1: After reset every register reads zero, status (offset 0x0C) reads 0x0003, interrupt status (0x14) reads 0x0002, `sclk` is low and `irq` is low.
- R2: The frame length is control-0 bits[3:0] plus one, and a value below 3 is treated as 3 (4-bit frames). Bits go out MSB first. Received data is right-justified with zero upper bits.
- R3: Control-0 bit 6 sets the idle level of `sclk`. With bit 7 clear, data is sampled on the edge that leaves idle and changed on the return. With bit 7 set, data is changed on the leaving edge and sampled on the return. Outside a frame, `sclk` stays at its idle level.
- R4: One `sclk` period lasts P×(1+S) clock cycles. S is control-0 bits[15:8]. P is the prescale register (0x10) with bit 0 forced to zero, and any P below 2 acts as 2. The prescale register reads back with bit 0 clear.
- R5: Writing offset 0x08 queues a word in an 8-deep transmit FIFO. A write while the FIFO is full is dropped. Status bit 0 means transmit empty and bit 1 means transmit not full.
- R6: Reading offset 0x08 pops the receive FIFO. Reading it while empty returns 0. Status bit 2 means receive not empty and bit 3 means receive full.
- R7: Status bit 4 (busy) is high while a frame is shifting or the transmit FIFO holds data.
- R8: With control-1 bit 3 set, the receiver takes the transmitter's own output bits instead of `miso`.
- R9: A frame that completes while the receive FIFO is full is discarded and sets interrupt-status bit 2. The flag stays set until any write to offset 0x14.
- R10: Writes to control 0 or prescale while the port is enabled do not change the frames sent. They take effect after control-1 bit 4 is cleared and set again.
- R11: Clearing control-1 bit 4 lets the frame in progress finish, starts no further frame, and leaves `sclk` at its idle level.
- R12: Interrupt-status bit 0 is receive not empty, bit 1 is transmit FIFO holding at most 4 words, and bit 2 is overrun. `irq` is the OR of these bits masked by control-1 bits[2:0] at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software never changes the configuration in a way that would alter a frame already shifting, and that each bus access lasts a single cycle. The bench writes control 0 and prescale only while the port is disabled and drained, except in the one deliberate test of writes made while enabled. The queue assertions assume pushes and pops arrive only when the queues have room or data. The bench reaches a full transmit queue and a full receive queue only through the register interface, which gates both.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int OFS_CR0 = 'h00;
  localparam int OFS_CR1 = 'h04;
  localparam int OFS_DAT = 'h08;
  localparam int OFS_STS = 'h0C;
  localparam int OFS_PRE = 'h10;
  localparam int OFS_INT = 'h14;

  // working copy of the serial settings
  typedef struct packed {
    logic [3:0] dss;
    logic       cpol;
    logic       cpha;
    logic [7:0] scr;
    logic [6:0] pre_half;
  } cfg_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;

  // R5: the register front end never pushes into a full queue
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));
  // R6: the register front end never pops an empty queue
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DW  = 16,
  parameter int HW  = 16,
  localparam int LW = $clog2(DW),
  localparam int EW = LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic [LW-1:0] last_bit,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [HW-1:0] half,
  input  logic          miso_in,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi
);
  logic          act_q, act_d, ph_q, ph_d, done_q, done_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [DW-1:0] txs_q, txs_d, rxs_q, rxs_d;
  logic          tick, lead, first, last_edge, smp, shf;
  logic [LW-1:0] sh_amt;

  assign sh_amt    = LW'(DW - 1) - last_bit;
  assign tick      = act_q && (cnt_q == half - 1'b1);
  assign lead      = ~ecnt_q[0];
  assign first     = (ecnt_q == '0);
  assign last_edge = (ecnt_q == EW'({last_bit, 1'b1}));
  assign smp       = cpha ? !lead : lead;
  assign shf       = (cpha ? (lead && !first) : !lead) && !last_edge;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    ecnt_d = ecnt_q;
    ph_d   = ph_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    done_d = 1'b0;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      ecnt_d = '0;
      ph_d   = 1'b0;
      txs_d  = tx_word << sh_amt;
      rxs_d  = '0;
    end else if (act_q) begin
      if (tick) begin
        cnt_d  = '0;
        ecnt_d = ecnt_q + 1'b1;
        ph_d   = ~ph_q;
        if (smp) rxs_d = {rxs_q[DW-2:0], miso_in};
        if (shf) txs_d = {txs_q[DW-2:0], 1'b0};
        if (last_edge) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      ph_q   <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      ecnt_q <= ecnt_d;
      ph_q   <= ph_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      done_q <= done_d;
    end
  end

  assign active  = act_q;
  assign done    = done_q;
  assign rx_word = rxs_q;
  assign sclk    = cpol ^ ph_q;
  assign mosi    = txs_q[DW-1];

  // R3: between frames the serial clock rests at its idle level
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (sclk == cpol));
  // R11: a new frame is only launched from idle
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 5,
  localparam int CNTW = $clog2(DEPTH) + 1,
  localparam int LW   = $clog2(DW),
  localparam int HW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  logic [15:0] cr0_q;
  logic [6:0]  cr1_q;
  logic [7:0]  pre_q;
  logic        ovr_q, ovr_d;
  cfg_t        live_cfg, cfg_q, cfg_eff;

  logic wr_en, rd_en, hit_cr0, hit_cr1, hit_dat, hit_sts, hit_pre, hit_int;
  logic frozen, start, eng_active, eng_done, miso_in;
  logic tx_push, tx_pop, rx_push, rx_pop, tx_full, tx_empty, rx_full, rx_empty;
  logic [CNTW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0]   tx_head, rx_head, rx_word;
  logic [LW-1:0]   last_bit;
  logic [HW-1:0]   half;
  logic [2:0]      int_raw;
  logic [4:0]      status;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign hit_cr0 = (bus_addr == AW'(OFS_CR0));
  assign hit_cr1 = (bus_addr == AW'(OFS_CR1));
  assign hit_dat = (bus_addr == AW'(OFS_DAT));
  assign hit_sts = (bus_addr == AW'(OFS_STS));
  assign hit_pre = (bus_addr == AW'(OFS_PRE));
  assign hit_int = (bus_addr == AW'(OFS_INT));

  // live settings decoded from the registers
  always_comb begin
    live_cfg.dss      = cr0_q[3:0];
    live_cfg.cpol     = cr0_q[6];
    live_cfg.cpha     = cr0_q[7];
    live_cfg.scr      = cr0_q[15:8];
    live_cfg.pre_half = (pre_q[7:1] == 7'd0) ? 7'd1 : pre_q[7:1];
  end

  assign frozen   = cr1_q[4] | eng_active | eng_done;
  assign cfg_eff  = frozen ? cfg_q : live_cfg;
  assign last_bit = (cfg_eff.dss < 4'd3) ? LW'(3) : LW'(cfg_eff.dss);
  assign half     = HW'(cfg_eff.pre_half) * (HW'(cfg_eff.scr) + 1'b1);

  assign tx_full  = (tx_cnt == CNTW'(DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == CNTW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);

  assign start   = cr1_q[4] & ~tx_empty & ~eng_active & ~eng_done;
  assign tx_push = wr_en & hit_dat & ~tx_full;
  assign tx_pop  = start;
  assign rx_push = eng_done & ~rx_full;
  assign rx_pop  = rd_en & hit_dat & ~rx_empty;
  assign miso_in = cr1_q[3] ? mosi : miso;

  always_comb begin
    ovr_d = ovr_q;
    if (wr_en && hit_int) ovr_d = 1'b0;
    if (eng_done && rx_full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q <= '0;
      cr1_q <= '0;
      pre_q <= '0;
      ovr_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (wr_en && hit_cr0) cr0_q <= bus_wdata[15:0];
      if (wr_en && hit_cr1) cr1_q <= bus_wdata[6:0];
      if (wr_en && hit_pre) pre_q <= {bus_wdata[7:1], 1'b0};
      ovr_q <= ovr_d;
      if (!frozen) cfg_q <= live_cfg;
    end
  end

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt));

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt));

  ssp_shifter #(.DW(DW), .HW(HW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_head),
    .last_bit(last_bit), .cpol(cfg_eff.cpol), .cpha(cfg_eff.cpha),
    .half(half), .miso_in(miso_in), .active(eng_active), .done(eng_done),
    .rx_word(rx_word), .sclk(sclk), .mosi(mosi));

  assign int_raw = {ovr_q, (tx_cnt <= CNTW'(DEPTH / 2)), ~rx_empty};
  assign irq     = |(int_raw & cr1_q[2:0]);
  assign status  = {~tx_empty | eng_active | eng_done, rx_full, ~rx_empty, ~tx_full, tx_empty};

  always_comb begin
    bus_rdata = '0;
    if (hit_cr0)                bus_rdata = DW'(cr0_q);
    else if (hit_cr1)           bus_rdata = DW'(cr1_q);
    else if (hit_dat)           bus_rdata = rx_empty ? '0 : rx_head;
    else if (hit_sts)           bus_rdata = DW'(status);
    else if (hit_pre)           bus_rdata = DW'(pre_q);
    else if (hit_int)           bus_rdata = DW'(int_raw);
  end

  // R9: the overrun flag only drops on a write to the clear location
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_en && hit_int)) |=> ovr_q);
  // R10: settings in use cannot move while a frame is shifting
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |=> (!eng_active || $stable(cfg_eff)));
  // R12: the interrupt line needs at least one enabled source
  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cr1_q[2:0] != 3'd0));
endmodule

// File: tb/tb_ssp_master.sv
`timescale 1ns/1ps
module tb_ssp_master;
  localparam int CR0 = 'h00, CR1 = 'h04, DAT = 'h08, STS = 'h0C, PRE = 'h10, INT = 'h14;

  logic clk, rst_n, bus_sel, bus_wr, miso;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic sclk, mosi, irq;

  ssp_master dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit ended = 0;

  // bench-side slave model state
  logic cpol_b = 0, cpha_b = 0, lbk_b = 0, prev_s = 0, in_frame = 0;
  int   nb = 8, bits_in = 0, fidx = 0, frames_done = 0;
  int   cyc = 0, last_lead = 0, leads = 0, meas_period = 0;
  logic [15:0] cur = 0;
  logic [15:0] exp_tx[$];
  logic [15:0] rxm[$];
  bit   ovr_exp = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(input int n);
    logic [16:0] t;
    t = (17'd1 << n) - 17'd1;
    return t[15:0];
  endfunction

  function automatic logic [15:0] swv(input int idx, input int n);
    return 16'(idx * 'h9E37 + 'h1234) & msk(n);
  endfunction

  // behavioural slave and per-clock idle check
  always @(negedge clk) begin
    logic lead, samp;
    logic [15:0] w, e, s;
    cyc++;
    if (rst_n && sclk !== prev_s) begin
      lead = (prev_s == cpol_b);
      if (lead) begin
        in_frame = 1;
        if (leads > 0) meas_period = cyc - last_lead;
        last_lead = cyc;
        leads++;
      end
      samp = cpha_b ? !lead : lead;
      if (samp) begin
        cur = {cur[14:0], mosi};
        bits_in++;
        if (bits_in == nb) begin
          if (exp_tx.size() == 0) chk(0, "R2 unexpected frame", cur, 0);
          else begin
            e = exp_tx.pop_front();
            chk(cur == e, "R2/R3 mosi frame", cur, e);
          end
          w = lbk_b ? cur : swv(fidx, nb);
          if (rxm.size() < 8) rxm.push_back(w); else ovr_exp = 1;
          fidx++; frames_done++; bits_in = 0; cur = 0; leads = 0;
        end
      end
      if (!lead && bits_in == 0) in_frame = 0;
      prev_s = sclk;
    end
    s = swv(fidx, nb);
    miso = s[nb-1-bits_in];
    if (rst_n && !in_frame && sclk !== cpol_b) chk(0, "R3 idle level", sclk, cpol_b);
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'(a);
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  // program settings while the port is disabled; the bench follows them
  task automatic cfg(input int dss, input bit pol, input bit pha, input int scr, input int pre);
    wr(PRE, 16'(pre));
    wr(CR0, {8'(scr), pha, pol, 2'b00, 4'(dss)});
    cpol_b = pol; cpha_b = pha; prev_s = pol;
    nb = (dss < 3) ? 4 : dss + 1;
    meas_period = 0;
  endtask

  task automatic send(input logic [15:0] w, input bit acc);
    wr(DAT, w);
    if (acc) exp_tx.push_back(w & msk(nb));
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int n = 0;
    do begin rd(STS, s); n++; end while (s[4] && n < 20000);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input int k, input string tag);
    logic [15:0] d, e;
    for (int i = 0; i < k; i++) begin
      rd(DAT, d);
      e = (rxm.size() > 0) ? rxm.pop_front() : 16'h0;
      chk(d == e, tag, d, e);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    int f0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; miso = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(STS, d); chk(d == 16'h0003, "R1 status after reset", d, 3);
    rd(CR0, d); chk(d == 0, "R1 control0 after reset", d, 0);
    rd(INT, d); chk(d == 16'h0002, "R1 int status after reset", d, 2);
    chk(sclk == 0 && irq == 0, "R1 sclk/irq after reset", {sclk, irq}, 0);

    // mode 0, 8 bits, fastest rate
    cfg(7, 0, 0, 0, 2);
    wr(CR1, 16'h0010);
    f0 = frames_done;
    send(16'h00A5, 1); send(16'h003C, 1); send(16'h01F0, 1);
    wait_idle();
    chk(frames_done - f0 == 3, "R2 frame count mode0", frames_done - f0, 3);
    chk(meas_period == 2, "R4 period pre2 scr0", meas_period, 2);
    wr(CR1, 16'h0011);
    chk(irq == 1, "R12 rx request irq", irq, 1);
    drain(3, "R6 rx data mode0");
    chk(irq == 0, "R12 irq after drain", irq, 0);
    rd(DAT, d); chk(d == 0, "R6 empty read", d, 0);
    rd(STS, d); chk(d == 16'h0003, "R6 status after drain", d, 3);

    // mode 3, 12 bits, P=4 (written 5), S=2
    wr(CR1, 0);
    cfg(11, 1, 1, 2, 5);
    rd(PRE, d); chk(d == 4, "R4 prescale bit0 cleared", d, 4);
    wr(CR1, 16'h0010);
    send(16'h0ABC, 1); send(16'hF123, 1);
    wait_idle();
    chk(meas_period == 12, "R4 period pre4 scr2", meas_period, 12);
    drain(2, "R3 rx data mode3");

    // mode 1, 16 bits, P below 2 acts as 2, S=1
    wr(CR1, 0);
    cfg(15, 0, 1, 1, 0);
    wr(CR1, 16'h0010);
    send(16'hC3A5, 1);
    wait_idle();
    chk(meas_period == 4, "R4 period pre0 scr1", meas_period, 4);
    drain(1, "R2 rx data 16 bits");

    // mode 2, size field 1 acts as 4 bits
    wr(CR1, 0);
    cfg(1, 1, 0, 3, 2);
    wr(CR1, 16'h0010);
    send(16'h00AB, 1); send(16'h0036, 1);
    wait_idle();
    chk(meas_period == 8, "R4 period pre2 scr3", meas_period, 8);
    drain(2, "R2 rx data 4-bit clamp");

    // loopback, 9 bits, mode 1
    wr(CR1, 0);
    cfg(8, 0, 1, 0, 2);
    lbk_b = 1;
    wr(CR1, 16'h0018);
    send(16'h01FF, 1); send(16'h0155, 1);
    wait_idle();
    drain(2, "R8 loopback data");
    wr(CR1, 0);
    lbk_b = 0;

    // R10: writes while enabled are held back
    cfg(7, 0, 0, 0, 2);
    wr(CR1, 16'h0010);
    wr(CR0, 16'h004F);
    send(16'h005A, 1);
    wait_idle();
    drain(1, "R10 old width kept while enabled");
    wr(CR1, 0);
    cpol_b = 1; prev_s = 1; nb = 16; cpha_b = 0;
    wr(CR1, 16'h0010);
    send(16'hBEEF, 1);
    wait_idle();
    drain(1, "R10 new width after re-enable");
    wr(CR1, 0);

    // R5 full transmit queue, R9 overrun
    cfg(7, 0, 0, 0, 2);
    for (int i = 0; i < 9; i++) send(16'(i * 17 + 3), i < 8);
    rd(STS, d); chk(d == 16'h0010, "R5 status tx full", d, 16'h10);
    rd(INT, d); chk(d == 0, "R12 tx request off when over half", d, 0);
    wr(CR1, 16'h0014);
    wait_idle();
    rd(STS, d); chk(d == 16'h000F, "R5/R6 status rx full", d, 16'hF);
    chk(irq == 0, "R9 no overrun yet", irq, 0);
    send(16'h0077, 1);
    wait_idle();
    chk(ovr_exp == 1, "R9 model saw overrun", ovr_exp, 1);
    chk(irq == 1, "R9 overrun irq", irq, 1);
    rd(INT, d); chk(d == 16'h0007, "R9 int status overrun", d, 7);
    wr(INT, 16'h0000);
    rd(INT, d); chk(d == 16'h0003, "R9 cleared by write", d, 3);
    chk(irq == 0, "R9 irq after clear", irq, 0);
    drain(8, "R9 kept frames");
    ovr_exp = 0;
    wr(CR1, 0);

    // R11 disable mid-frame
    cfg(7, 0, 0, 3, 8);
    wr(CR1, 16'h0010);
    f0 = frames_done;
    send(16'h0081, 1); send(16'h0042, 1);
    repeat (20) @(negedge clk);
    wr(CR1, 0);
    repeat (300) @(negedge clk);
    chk(frames_done - f0 == 1, "R11 frame finished, none started", frames_done - f0, 1);
    rd(STS, d); chk(d == 16'h0016, "R7/R11 busy with pending data", d, 16'h16);
    chk(sclk == 0, "R11 sclk idle", sclk, 0);
    wr(CR1, 16'h0010);
    wait_idle();
    chk(frames_done - f0 == 2, "R11 pending frame after re-enable", frames_done - f0, 2);
    drain(2, "R11 rx data");
    chk(exp_tx.size() == 0, "R5 all queued frames sent", exp_tx.size(), 0);

    finish_up();
  end
endmodule